// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits beside a flash-style command decoder and stands in for the array while an internal program, erase or protection-lock operation runs. When the decoder hands it a start pulse, it records the kind of operation and the byte being written. It then holds a busy flag for a fixed number of clock cycles, and that number depends on the kind of operation.

While the flag is up, the byte the block drives back to the host is not array data. It is an in-band status word. Bit 7 is a polling bit: for a program it is the inverse of the most significant bit of the byte being written, and for the other operations it is 0. Bit 6 flips on every read access. Bits 5 to 0 are 0. Software polls the bus in one of two ways: it waits for bit 7 to match its data, or it waits for bit 6 to stop changing.

When the operation finishes, the block drops busy and raises a one-cycle done pulse so the decoder can return to its read state. From then on it passes the array read data straight through. The durations are parameters in clock cycles, so a fast simulation can use small values and silicon can use values in the microsecond to hundreds-of-millisecond range.

Top module: `embed_op_status`

## Requirements
- R1: After reset, busy and done are 0 and dataOut equals arrayData.
- R2: A startPulse taken while busy is 0 raises busy at the next clock edge. Busy then stays high for exactly PROG_CYCLES cycles for opType 0 (program), ERASE_CYCLES for opType 1 (block erase) and opType 2 (chip erase), and LOCK_CYCLES for opType 3 (lockout).
- R3: While a program (opType 0) is busy, dataOut[7] is the inverse of lastByte[7] as sampled with the accepted start.
- R4: While an erase or lockout (opType 1, 2 or 3) is busy, dataOut[7] is 0.
- R5: dataOut[6] is 0 in the first busy cycle after an accepted start. It inverts after each clock edge at which readStrobe is 1 while busy, and it holds when readStrobe is 0.
- R6: While busy, dataOut[5:0] is 0.
- R7: While busy is 0, dataOut equals arrayData in the same cycle.
- R8: done is 1 for exactly one cycle, which is the first cycle in which busy is 0 after an operation. At all other times done is 0.
- R9: A startPulse that arrives while busy is 1 is ignored. The running operation's duration, its bit 7 and its toggle sequence are unchanged.
- R10: A startPulse in the cycle in which done is 1 is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startPulse | input | 1 | Start request from the command decoder |
| opType | input | 2 | Operation kind: 0 program, 1 block erase, 2 chip erase, 3 lockout |
| lastByte | input | 8 | Byte written by the command that starts the operation |
| arrayData | input | 8 | Read data from the array |
| readStrobe | input | 1 | One-cycle pulse per host read access |
| dataOut | output | 8 | Byte returned to the host |
| busy | output | 1 | An operation is running |
| done | output | 1 | One-cycle pulse when an operation ends |

## Verification
The checker checks the following on every cycle:
- dataOut[5:0] is zero during busy.
- Data passes through while idle.
- The polling bit has the right value in the cycle after a start.
- Bit 6 inverts on every strobed read and holds otherwise.
- Bit 7 stays stable for the whole operation.
- done is a single cycle that coincides with the fall of busy.
- No busy run is longer than the longest duration.

The exact length of each operation kind can only be shown by the bench's scenarios. The same holds for ignoring a start while busy, for accepting a start in the done cycle, and for a strobe that arrives in the same cycle as a start. The bench checks these against its cycle-by-cycle reference model.

// File: rtl/op_status_pkg.sv
package op_status_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM     = 2'd0,
    OP_BLOCK_ERASE = 2'd1,
    OP_CHIP_ERASE  = 2'd2,
    OP_LOCKOUT     = 2'd3
  } opKindT;

  typedef struct packed {
    logic loadOp;   // accepted start: capture poll bit, clear toggle
    logic busyNow;  // operation in progress
  } ctrlStrobeT;

endpackage

// File: rtl/op_status_ctrl.sv
module op_status_ctrl
  import op_status_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  parameter int LOCK_CYCLES  = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  opKindT     opKind,
  output ctrlStrobeT strb,
  output logic       busy,
  output logic       done
);

  localparam int MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAX_CYC = (MAX_A > LOCK_CYCLES) ? MAX_A : LOCK_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cntR;
  logic [CNT_W-1:0] loadVal;
  logic             busyR;
  logic             doneR;
  logic             accept;

  assign accept = startPulse && !busyR;

  // Counter starts at duration-1 so busy is high for exactly the duration.
  always_comb begin
    unique case (opKind)
      OP_PROGRAM:                    loadVal = CNT_W'(PROG_CYCLES - 1);
      OP_BLOCK_ERASE, OP_CHIP_ERASE: loadVal = CNT_W'(ERASE_CYCLES - 1);
      default:                       loadVal = CNT_W'(LOCK_CYCLES - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0;
      doneR <= 1'b0;
      cntR  <= '0;
    end else begin
      doneR <= 1'b0;
      if (accept) begin
        busyR <= 1'b1;
        cntR  <= loadVal;
      end else if (busyR) begin
        if (cntR == '0) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end else begin
          cntR <= cntR - 1'b1;
        end
      end
    end
  end

  assign strb.loadOp  = accept;
  assign strb.busyNow = busyR;
  assign busy         = busyR;
  assign done         = doneR;

endmodule

// File: rtl/op_status_datapath.sv
module op_status_datapath
  import op_status_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strb,
  input  opKindT            opKind,
  input  logic [DATA_W-1:0] lastByte,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              readStrobe,
  output logic [DATA_W-1:0] dataOut
);

  logic pollR;
  logic toggleR;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollR   <= 1'b0;
      toggleR <= 1'b0;
    end else if (strb.loadOp) begin
      pollR   <= (opKind == OP_PROGRAM) ? ~lastByte[POLL_BIT] : 1'b0;
      toggleR <= 1'b0;
    end else if (strb.busyNow && readStrobe) begin
      toggleR <= ~toggleR;
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[POLL_BIT] = pollR;
    statusWord[TOG_BIT]  = toggleR;
  end

  assign dataOut = strb.busyNow ? statusWord : arrayData;

endmodule

// File: rtl/embed_op_status.sv
module embed_op_status
  import op_status_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  parameter int LOCK_CYCLES  = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic [1:0] opType,
  input  logic [7:0] lastByte,
  input  logic [7:0] arrayData,
  input  logic       readStrobe,
  output logic [7:0] dataOut,
  output logic       busy,
  output logic       done
);

  ctrlStrobeT strb;
  opKindT     opKind;

  assign opKind = opKindT'(opType);

  op_status_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .LOCK_CYCLES (LOCK_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .opKind    (opKind),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  op_status_datapath #(
    .DATA_W  (8),
    .POLL_BIT(7),
    .TOG_BIT (6)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opKind    (opKind),
    .lastByte  (lastByte),
    .arrayData (arrayData),
    .readStrobe(readStrobe),
    .dataOut   (dataOut)
  );

endmodule

// File: rtl/op_status_checker.sv
module op_status_checker #(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 64,
  parameter int LOCK_CYCLES  = 128
) (
  input logic       clk,
  input logic       rstN,
  input logic       startPulse,
  input logic [1:0] opType,
  input logic [7:0] lastByte,
  input logic [7:0] arrayData,
  input logic       readStrobe,
  input logic [7:0] dataOut,
  input logic       busy,
  input logic       done
);

  localparam int MAX_A   = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int MAX_CYC = (MAX_A > LOCK_CYCLES) ? MAX_A : LOCK_CYCLES;

  int busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  // R2: no busy run exceeds the longest duration
  a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= MAX_CYC);

  a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !busy && opType == 2'd0 |=> dataOut[7] == !$past(lastByte[7]));

  a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !busy && opType != 2'd0 |=> dataOut[7] == 1'b0);

  a_r5_toggle_clear: assert property (@(posedge clk) disable iff (!rstN)
    startPulse && !busy |=> dataOut[6] == 1'b0);

  a_r5_toggle_flip: assert property (@(posedge clk) disable iff (!rstN)
    busy && readStrobe |=> !busy || dataOut[6] != $past(dataOut[6]));

  a_r5_toggle_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy && !readStrobe |=> !busy || $stable(dataOut[6]));

  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> dataOut[5:0] == 6'd0);

  a_r7_pass: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> dataOut == arrayData);

  a_r8_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> busy || done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  a_r9_poll_stable: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy || $stable(dataOut[7]));

endmodule

bind embed_op_status op_status_checker #(
  .PROG_CYCLES (PROG_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES),
  .LOCK_CYCLES (LOCK_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startPulse(startPulse),
  .opType    (opType),
  .lastByte  (lastByte),
  .arrayData (arrayData),
  .readStrobe(readStrobe),
  .dataOut   (dataOut),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_embed_op_status.sv
`timescale 1ns/1ps
module sim_embed_op_status;

  localparam int P_CYC = 5;
  localparam int E_CYC = 12;
  localparam int L_CYC = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [1:0] opType = 2'd0;
  logic [7:0] lastByte = 8'h00;
  logic [7:0] arrayData = 8'h00;
  logic       readStrobe = 1'b0;
  logic [7:0] dataOut;
  logic       busy;
  logic       done;

  int errors = 0;
  int checks = 0;
  bit started = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  embed_op_status #(
    .PROG_CYCLES (P_CYC),
    .ERASE_CYCLES(E_CYC),
    .LOCK_CYCLES (L_CYC)
  ) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opType(opType),
    .lastByte(lastByte), .arrayData(arrayData), .readStrobe(readStrobe),
    .dataOut(dataOut), .busy(busy), .done(done)
  );

  // Behavioural reference model
  bit   mBusy = 0, mDone = 0, mPoll = 0, mToggle = 0;
  int   mLeft = 0;

  function automatic int durOf(logic [1:0] t);
    if (t == 2'd0) return P_CYC;
    if (t == 2'd3) return L_CYC;
    return E_CYC;
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rstN) begin
      mBusy <= 0; mDone <= 0; mPoll <= 0; mToggle <= 0; mLeft <= 0;
    end else begin
      mDone <= 0;
      if (startPulse && !mBusy) begin
        mBusy   <= 1;
        mLeft   <= durOf(opType);
        mPoll   <= (opType == 2'd0) ? !lastByte[7] : 1'b0;
        mToggle <= 0;
      end else if (mBusy) begin
        if (readStrobe) mToggle <= !mToggle;
        if (mLeft == 1) begin mBusy <= 0; mDone <= 1; end
        else mLeft <= mLeft - 1;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare on every cycle away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      if (!rstN) begin
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
      end else begin
        check("R2 busy", busy, mBusy);
        check("R8 done", done, mDone);
        if (mBusy) begin
          check(mPoll ? "R3 bit7" : "R3/R4 bit7", dataOut[7], mPoll);
          check("R5 bit6", dataOut[6], mToggle);
          check("R6 bits5-0", dataOut[5:0], 0);
        end else begin
          check("R7 pass", dataOut, arrayData);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk); #1;
      arrayData = 8'($urandom);
    end
  endtask

  task automatic startOp(logic [1:0] t, logic [7:0] b);
    startPulse = 1; opType = t; lastByte = b;
    tick(1);
    startPulse = 0;
  endtask

  task automatic runStrobe(int n, int every);
    for (int i = 0; i < n; i++) begin
      readStrobe = (every != 0) && (i % every == 0);
      tick(1);
    end
    readStrobe = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    tick(3);                    // R1: reset state
    rstN = 1;
    tick(3);                    // R7: idle pass-through
    runStrobe(4, 1);            // idle strobes have no effect
    startOp(2'd0, 8'h80);       // R3 program, bit7 of byte = 1
    runStrobe(P_CYC + 3, 1);    // R5 every read
    startOp(2'd0, 8'h3C);       // R3 program, bit7 of byte = 0
    runStrobe(P_CYC + 2, 2);
    startOp(2'd1, 8'hFF);       // R4 block erase
    runStrobe(E_CYC + 2, 3);
    startOp(2'd2, 8'h00);       // R4 chip erase, R5 toggle without strobes
    runStrobe(E_CYC + 2, 0);
    readStrobe = 1;             // R5: strobe in start cycle, toggle still cleared
    startOp(2'd3, 8'hA5);       // R2 lockout duration
    runStrobe(3, 1);
    startOp(2'd0, 8'h00);       // R9: ignored start while busy
    runStrobe(L_CYC, 1);
    startOp(2'd0, 8'h7F);       // program; then R10 start in done cycle
    runStrobe(P_CYC, 1);
    startOp(2'd1, 8'h11);       // lands in done cycle
    runStrobe(E_CYC + 3, 1);
    rstN = 0;                   // R1 again mid-run
    startOp(2'd2, 8'h00);
    tick(2);
    rstN = 1;
    tick(3);
    summary();
  end

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    summary();
  end

endmodule